// File: doc/BRIEF.md
# HDLC Serial Frame Transmitter

This block turns a stream of octets into an HDLC-style line bit stream. Octets arrive on a byte-wide ready/valid port. Each octet carries a start-of-frame mark and an end-of-frame mark. The block sends one line bit in each cycle where `bit_en` is high. A frame is sent as follows:

1. An opening delimiter.
2. The frame body, least significant bit first.
3. A 16-bit frame check word, computed over the body bits before any zeros are inserted.
4. A closing delimiter.

Within the body and the check word, a zero is inserted after every run of five ones. Between frames the line carries fill. A configuration input selects whether the fill is back-to-back delimiters or a steady run of ones. A frame can be cut short with an abort request. The transmitter also aborts by itself when the source cannot supply the next octet in time.

The control is one state machine with six states:

- `ST_FILL`: sends interframe fill.
- `ST_OPEN`: sends the opening delimiter.
- `ST_BODY`: serialises the frame body.
- `ST_FCS`: serialises the check word.
- `ST_CLOSE`: sends the closing delimiter.
- `ST_ABORT`: sends the run of ones that marks an abort.

The transitions are:

| From | To | Condition |
|---|---|---|
| `ST_FILL` | `ST_OPEN` | A start octet is buffered at a delimiter boundary. |
| `ST_OPEN` | `ST_BODY` | The delimiter is complete and the first octet is taken. |
| `ST_BODY` | `ST_FCS` | The last body bit has been sent. |
| `ST_BODY` | `ST_ABORT` | An abort request, or an underrun. |
| `ST_FCS` | `ST_CLOSE` | Sixteen check bits have been sent. |
| `ST_FCS` | `ST_ABORT` | An abort request. |
| `ST_CLOSE` | `ST_FILL` | The closing delimiter is complete. |
| `ST_ABORT` | `ST_FILL` | The abort run is complete. |

A one-octet holding register sits between the input port and the serialiser.

Top module: `hdlc_tx`

## Requirements
- R1: After reset `tx_bit` is 1, `in_ready` is 1 and the block is sending fill.
- R2: Every frame begins with the delimiter 01111110 and ends with the same delimiter, and neither delimiter receives inserted zeros.
- R3: In the body and the check word, a 0 is inserted after every five consecutive ones. The run count carries across octet boundaries and across the body/check boundary, and a pending insertion is made before the closing delimiter. No run of more than five ones appears between the delimiters.
- R4: Body octets are serialised bit 0 first. One line bit is sent per `bit_en` slot, and the frame carries the octets in the order accepted.
- R5: The check word works as follows:
  - The register is preset to 0xFFFF. It is updated for each body bit, in line order, with the reflected generator 0x8408 (x^16+x^12+x^5+1). Inserted zeros are not included.
  - The complement of the final value is sent low byte first, bit 0 first.
  - For the body "123456789" the check octets are 0x6E then 0x90.
  - Running the same update over the body and check bits leaves 0xF0B8.
- R6: With `idle_ones`=1 the fill is all ones. With `idle_ones`=0 the fill is back-to-back 01111110 delimiters aligned to 8-slot boundaries.
- R7: If `abort_req` is high in a body or check slot, the block ends the frame with at least seven consecutive ones and no inserted zeros, then returns to fill. In fill, `abort_req` has no effect.
- R8: If a body octet that is not marked end-of-frame finishes and no next octet is buffered, the block aborts as in R7.
- R9: `in_ready` is high exactly when the holding register is empty. A buffered octet stays unchanged until it is taken, so a stalled source loses no octet.
- R10: An octet marked both start and end of frame (a one-octet body) is accepted and discarded, and no frame is sent. An octet without a start mark that arrives during fill is also discarded.
- R11: In a cycle where `bit_en` is low, `tx_bit` and the state do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Line bit slot strobe; one line bit is produced per strobe |
| idle_ones | input | 1 | Fill selection: 1 selects all ones, 0 selects repeated delimiters |
| abort_req | input | 1 | Request to abort the frame in progress |
| in_data | input | 8 | Octet to send |
| in_valid | input | 1 | `in_data` and the marks are valid |
| in_sof | input | 1 | The octet is the first of a frame |
| in_eof | input | 1 | The octet is the last of a frame |
| in_ready | output | 1 | The holding register can take an octet |
| tx_bit | output | 1 | Serial line bit |

## Verification
`tx_bit` is registered. The bit chosen in a slot appears one clock after the rising edge at which `bit_en` was sampled high. The bench therefore keeps a copy of `bit_en` delayed by one edge and records `tx_bit` on the falling edge only when that copy is high. A frame takes several slots to start: up to eight slots of fill until the next delimiter boundary, then eight slots of opening delimiter. For this reason the bench does not check fixed cycle numbers; it captures a generous window of slots and decodes the whole stream (delimiters, zero removal, octets and check word) against its own model. `in_ready` follows the holding register one edge after a handshake or a take, so the bench judges acceptance on the falling edge before each rising edge.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    typedef enum logic [2:0] {
        ST_FILL,
        ST_OPEN,
        ST_BODY,
        ST_FCS,
        ST_CLOSE,
        ST_ABORT
    } tx_state_e;

    localparam int          DELIM_W   = 8;
    localparam logic [7:0]  DELIM_PAT = 8'h7E;

endpackage

// File: rtl/hdlc_fcs16.sv
module hdlc_fcs16 #(
    parameter int               CRC_W = 16,
    parameter logic [CRC_W-1:0] POLY  = 16'h8408,
    parameter logic [CRC_W-1:0] INIT  = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             preset,
    input  logic             step,
    input  logic             din,
    output logic [CRC_W-1:0] crc,
    output logic [CRC_W-1:0] crc_nx
);

    // reflected update: shift right, fold generator when the outgoing bit differs
    always_comb begin
        crc_nx = crc >> 1;
        if (crc[0] ^ din) begin
            crc_nx = crc_nx ^ POLY;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || preset) begin
            crc <= INIT;
        end else if (step) begin
            crc <= crc_nx;
        end
    end

endmodule

// File: rtl/hdlc_in_buf.sv
module hdlc_in_buf #(
    parameter int OCT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OCT_W-1:0] in_data,
    input  logic             in_sof,
    input  logic             in_eof,
    output logic             in_ready,
    input  logic             take,
    output logic             vld,
    output logic [OCT_W-1:0] data_q,
    output logic             sof_q,
    output logic             eof_q
);

    assign in_ready = !vld;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld    <= 1'b0;
            data_q <= '0;
            sof_q  <= 1'b0;
            eof_q  <= 1'b0;
        end else if (in_valid && !vld) begin
            vld    <= 1'b1;
            data_q <= in_data;
            sof_q  <= in_sof;
            eof_q  <= in_eof;
        end else if (take) begin
            vld <= 1'b0;
        end
    end

    // R9: a held octet is neither dropped nor overwritten until taken
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !take) |=> (vld && $stable(data_q) && $stable(eof_q) && $stable(sof_q)));

    // R9: an offer while full is not accepted
    p_full_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !take && in_valid) |=> $stable(data_q));

endmodule

// File: rtl/hdlc_tx.sv
module hdlc_tx
    import hdlc_tx_pkg::*;
#(
    parameter int               OCT_W     = 8,
    parameter int               FCS_W     = 16,
    parameter int               RUN_MAX   = 5,
    parameter int               ABORT_LEN = 8,
    parameter logic [FCS_W-1:0] FCS_POLY  = 16'h8408,
    parameter logic [FCS_W-1:0] FCS_INIT  = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             idle_ones,
    input  logic             abort_req,
    input  logic [OCT_W-1:0] in_data,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    output logic             in_ready,
    output logic             tx_bit
);

    localparam int CNT_W  = $clog2(FCS_W + ABORT_LEN + DELIM_W);
    localparam int ONES_W = $clog2(RUN_MAX + 1);
    localparam int SH_W   = (FCS_W > OCT_W) ? FCS_W : OCT_W;

    localparam logic [CNT_W-1:0]  OCT_LAST   = CNT_W'(OCT_W - 1);
    localparam logic [CNT_W-1:0]  FCS_LAST   = CNT_W'(FCS_W - 1);
    localparam logic [CNT_W-1:0]  DELIM_LAST = CNT_W'(DELIM_W - 1);
    localparam logic [CNT_W-1:0]  ABORT_LAST = CNT_W'(ABORT_LEN - 1);
    localparam logic [ONES_W-1:0] RUN_LIM    = ONES_W'(RUN_MAX);

    tx_state_e         state, st_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [ONES_W-1:0] ones, ones_n;
    logic [SH_W-1:0]   sh, sh_n;
    logic              cur_eof, eof_n;
    logic              bit_n;

    logic              buf_vld, buf_sof, buf_eof, buf_take;
    logic [OCT_W-1:0]  buf_data;
    logic              slot_take, drop;
    logic              start_ok, stuff_now, delim_bit;
    logic              crc_preset, crc_step;
    logic [FCS_W-1:0]  crc, crc_nx;

    hdlc_in_buf #(.OCT_W(OCT_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_sof   (in_sof),
        .in_eof   (in_eof),
        .in_ready (in_ready),
        .take     (buf_take),
        .vld      (buf_vld),
        .data_q   (buf_data),
        .sof_q    (buf_sof),
        .eof_q    (buf_eof)
    );

    hdlc_fcs16 #(.CRC_W(FCS_W), .POLY(FCS_POLY), .INIT(FCS_INIT)) u_fcs (
        .clk    (clk),
        .rst_n  (rst_n),
        .preset (crc_preset),
        .step   (crc_step),
        .din    (sh[0]),
        .crc    (crc),
        .crc_nx (crc_nx)
    );

    assign start_ok  = buf_vld && buf_sof && !buf_eof;
    assign drop      = (state == ST_FILL) && buf_vld && !start_ok;
    assign buf_take  = slot_take || drop;
    assign delim_bit = DELIM_PAT[cnt[2:0]];
    assign stuff_now = ((state == ST_BODY) || (state == ST_FCS) || (state == ST_CLOSE))
                       && (ones == RUN_LIM);

    // next-state and datapath decisions, all taken in a bit slot
    always_comb begin
        st_n       = state;
        cnt_n      = cnt;
        ones_n     = ones;
        sh_n       = sh;
        eof_n      = cur_eof;
        bit_n      = tx_bit;
        slot_take  = 1'b0;
        crc_preset = 1'b0;
        crc_step   = 1'b0;
        if (bit_en) begin
            unique case (state)
                ST_FILL: begin
                    bit_n  = idle_ones ? 1'b1 : delim_bit;
                    ones_n = '0;
                    if (cnt == DELIM_LAST) begin
                        cnt_n = '0;
                        if (start_ok) begin
                            st_n = ST_OPEN;
                        end
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                ST_OPEN: begin
                    bit_n      = delim_bit;
                    ones_n     = '0;
                    crc_preset = 1'b1;
                    if (cnt == DELIM_LAST) begin
                        st_n      = ST_BODY;
                        cnt_n     = '0;
                        sh_n      = SH_W'(buf_data);
                        eof_n     = buf_eof;
                        slot_take = 1'b1;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                ST_BODY: begin
                    if (abort_req) begin
                        st_n   = ST_ABORT;
                        cnt_n  = '0;
                        bit_n  = 1'b1;
                        ones_n = '0;
                    end else if (stuff_now) begin
                        bit_n  = 1'b0;
                        ones_n = '0;
                    end else begin
                        bit_n    = sh[0];
                        crc_step = 1'b1;
                        ones_n   = sh[0] ? ones + 1'b1 : '0;
                        sh_n     = sh >> 1;
                        if (cnt == OCT_LAST) begin
                            cnt_n = '0;
                            if (cur_eof) begin
                                st_n = ST_FCS;
                                sh_n = SH_W'(~crc_nx);
                            end else if (buf_vld) begin
                                sh_n      = SH_W'(buf_data);
                                eof_n     = buf_eof;
                                slot_take = 1'b1;
                            end else begin
                                st_n = ST_ABORT;
                            end
                        end else begin
                            cnt_n = cnt + 1'b1;
                        end
                    end
                end
                ST_FCS: begin
                    if (abort_req) begin
                        st_n   = ST_ABORT;
                        cnt_n  = '0;
                        bit_n  = 1'b1;
                        ones_n = '0;
                    end else if (stuff_now) begin
                        bit_n  = 1'b0;
                        ones_n = '0;
                    end else begin
                        bit_n  = sh[0];
                        ones_n = sh[0] ? ones + 1'b1 : '0;
                        sh_n   = sh >> 1;
                        if (cnt == FCS_LAST) begin
                            st_n  = ST_CLOSE;
                            cnt_n = '0;
                        end else begin
                            cnt_n = cnt + 1'b1;
                        end
                    end
                end
                ST_CLOSE: begin
                    ones_n = '0;
                    if (stuff_now) begin
                        bit_n = 1'b0;
                    end else begin
                        bit_n = delim_bit;
                        if (cnt == DELIM_LAST) begin
                            st_n  = ST_FILL;
                            cnt_n = '0;
                        end else begin
                            cnt_n = cnt + 1'b1;
                        end
                    end
                end
                ST_ABORT: begin
                    bit_n  = 1'b1;
                    ones_n = '0;
                    if (cnt == ABORT_LAST) begin
                        st_n  = ST_FILL;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                default: begin
                    st_n  = ST_FILL;
                    cnt_n = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_FILL;
            cnt     <= '0;
            ones    <= '0;
            sh      <= '0;
            cur_eof <= 1'b0;
        end else begin
            state   <= st_n;
            cnt     <= cnt_n;
            ones    <= ones_n;
            sh      <= sh_n;
            cur_eof <= eof_n;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_bit <= 1'b1;
        end else begin
            tx_bit <= bit_n;
        end
    end

    // R3: a full run of ones in the body is followed by an inserted zero
    p_stuff_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !abort_req && ones == RUN_LIM &&
         (state == ST_BODY || state == ST_FCS || state == ST_CLOSE)) |=> !tx_bit);

    // R3: the run counter never passes the limit
    p_run_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ones <= RUN_LIM);

    // R6: ones fill puts only ones on the line
    p_fill_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && state == ST_FILL && idle_ones) |=> tx_bit);

    // R7: an abort request in the body or check word starts the abort run
    p_abort_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && abort_req && (state == ST_BODY || state == ST_FCS))
        |=> (state == ST_ABORT && tx_bit));

    // R7: the abort run is all ones
    p_abort_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && state == ST_ABORT) |=> tx_bit);

    // R10: a one-octet body or an unmarked octet is discarded during fill
    p_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && buf_vld && (buf_eof || !buf_sof)) |=> !buf_vld);

    // R11: nothing advances without a slot strobe
    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(tx_bit) && $stable(state) && $stable(cnt)));

endmodule

// File: tb/hdlc_tx_tb.sv
module hdlc_tx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       idle_ones = 1'b1;
    logic       abort_req = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_sof = 1'b0;
    logic       in_eof = 1'b0;
    wire        in_ready;
    wire        tx_bit;

    hdlc_tx u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .idle_ones (idle_ones),
        .abort_req (abort_req),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .in_ready  (in_ready),
        .tx_bit    (tx_bit)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;

    // stimulus/expect table: [83:80] body length, [79:0] octets, octet 0 in the low byte
    localparam int NVEC = 5;
    localparam logic [83:0] VEC [0:NVEC-1] = '{
        {4'd2, 80'h0000},
        {4'd3, 80'hFFFFFF},
        {4'd2, 80'h7E7E},
        {4'd4, 80'h80F83F01},
        {4'd9, 80'h00393837363534333231}
    };

    // slot strobe generator
    int   en_div = 1;
    int   en_ph = 0;
    logic run_en = 1'b0;
    always @(negedge clk) begin
        if (en_ph >= en_div - 1) begin
            en_ph  <= 0;
            bit_en <= run_en;
        end else begin
            en_ph  <= en_ph + 1;
            bit_en <= 1'b0;
        end
    end

    // line capture: a slot's bit is visible after the edge that sampled bit_en
    logic en_q = 1'b0;
    always @(posedge clk) en_q <= bit_en;

    logic cap [0:4095];
    int   cap_n = 0;
    int   quiet_viol = 0;
    logic cap_on = 1'b0;
    logic cap_clr = 1'b0;
    logic last_bit = 1'b1;
    always @(negedge clk) begin
        last_bit <= tx_bit;
        if (cap_clr) begin
            cap_n      <= 0;
            quiet_viol <= 0;
        end else if (cap_on) begin
            if (en_q && cap_n < 4096) begin
                cap[cap_n] <= tx_bit;
                cap_n      <= cap_n + 1;
            end
            if (!en_q && tx_bit != last_bit) quiet_viol <= quiet_viol + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cap_start();
        cap_on  = 1'b0;
        cap_clr = 1'b1;
        @(posedge clk);
        @(posedge clk);
        cap_clr = 1'b0;
        cap_on  = 1'b1;
        @(negedge clk);
    endtask

    task automatic push(input logic [7:0] d, input bit s, input bit e);
        in_data  = d;
        in_sof   = s;
        in_eof   = e;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
    endtask

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic [15:0] r;
        r = c >> 1;
        if (c[0] ^ b) r = r ^ 16'h8408;
        return r;
    endfunction

    function automatic logic [15:0] model_fcs(input logic [79:0] d, input int n);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int i = 0; i < n; i++)
            for (int k = 0; k < 8; k++)
                c = crc_step(c, d[8*i+k]);
        return ~c;
    endfunction

    function automatic bit is_delim(input int i);
        if (i + 8 > cap_n) return 1'b0;
        if (cap[i] !== 1'b0 || cap[i+7] !== 1'b0) return 1'b0;
        for (int k = 1; k < 7; k++)
            if (cap[i+k] !== 1'b1) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int max_run(input int from, input int upto);
        int run;
        int best;
        run = 0;
        best = 0;
        for (int i = from; i < upto; i++) begin
            if (cap[i] === 1'b1) run++; else run = 0;
            if (run > best) best = run;
        end
        return best;
    endfunction

    // decoded frame
    logic [7:0]  dec [0:31];
    int          dec_n;
    int          dec_run;
    bit          dec_ok;
    logic [15:0] dec_resid;

    task automatic decode();
        int p;
        int j;
        int ones;
        int nb;
        logic [15:0] c;
        dec_ok = 1'b0;
        dec_n = 0;
        dec_run = 99;
        p = 0;
        while (p < cap_n && !is_delim(p)) p++;
        if (p >= cap_n) return;
        while (is_delim(p)) p += 8;
        j = p;
        while (j < cap_n && !is_delim(j)) j++;
        if (j >= cap_n) return;
        dec_run = max_run(p, j);
        for (int i = 0; i < 32; i++) dec[i] = 8'h00;
        ones = 0;
        nb = 0;
        c = 16'hFFFF;
        for (int k = p; k < j; k++) begin
            if (ones == 5) begin
                ones = 0;
            end else begin
                if (nb < 256) dec[nb/8][nb%8] = cap[k];
                c = crc_step(c, cap[k]);
                nb++;
                ones = (cap[k] === 1'b1) ? ones + 1 : 0;
            end
        end
        dec_resid = c;
        if (nb % 8 != 0) return;
        dec_n = nb / 8;
        dec_ok = 1'b1;
    endtask

    task automatic send_frame(input int n, input logic [79:0] d);
        for (int i = 0; i < n; i++)
            push(d[8*i +: 8], i == 0, i == n - 1);
    endtask

    task automatic check_frame(input int n, input logic [79:0] d, input string tag);
        logic [15:0] f;
        bit same;
        decode();
        chk(dec_ok && dec_n == n + 2, "R2", {tag, " delimited frame length"}, dec_n, n + 2);
        same = 1'b1;
        for (int i = 0; i < n; i++)
            if (dec[i] !== d[8*i +: 8]) same = 1'b0;
        chk(same, "R4", {tag, " body octets"}, dec[0], d[7:0]);
        f = model_fcs(d, n);
        chk(dec[n] === f[7:0] && dec[n+1] === f[15:8], "R5", {tag, " check word"},
            {dec[n+1], dec[n]}, f);
        chk(dec_resid == 16'hF0B8, "R5", {tag, " residue"}, dec_resid, 16'hF0B8);
        chk(dec_run <= 5, "R3", {tag, " longest body run"}, dec_run, 5);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int p;
        int e;
        bit ok;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(tx_bit === 1'b1, "R1", "tx_bit in reset", tx_bit, 1);
        chk(in_ready === 1'b1, "R1", "in_ready in reset", in_ready, 1);
        rst_n = 1'b1;
        run_en = 1'b1;

        // R6: all-ones fill
        idle_ones = 1'b1;
        cap_start();
        repeat (48) @(negedge clk);
        ok = (cap_n > 30);
        for (int i = 0; i < cap_n; i++) if (cap[i] !== 1'b1) ok = 1'b0;
        chk(ok, "R6", "ones fill", cap_n, 48);

        // R6: delimiter fill
        idle_ones = 1'b0;
        repeat (20) @(negedge clk);
        cap_start();
        repeat (48) @(negedge clk);
        p = 0;
        while (p < 8 && !is_delim(p)) p++;
        chk(p < 8 && is_delim(p + 8) && is_delim(p + 16) && is_delim(p + 24), "R6",
            "delimiter fill", p, 0);

        // vector table, ones fill
        idle_ones = 1'b1;
        repeat (20) @(negedge clk);
        for (int v = 0; v < NVEC; v++) begin
            cap_start();
            send_frame(int'(VEC[v][83:80]), VEC[v][79:0]);
            repeat (300) @(negedge clk);
            check_frame(int'(VEC[v][83:80]), VEC[v][79:0], $sformatf("vec%0d", v));
        end
        // R5: known body gives known check octets (last table entry)
        chk(dec[9] === 8'h6E && dec[10] === 8'h90, "R5", "check for 123456789",
            {dec[10], dec[9]}, 16'h906E);

        // frame under delimiter fill
        idle_ones = 1'b0;
        cap_start();
        send_frame(3, 80'hC3FF5A);
        repeat (300) @(negedge clk);
        check_frame(3, 80'hC3FF5A, "flagfill");

        // R11: slow slot strobe, bit held between slots
        en_div = 3;
        idle_ones = 1'b1;
        repeat (30) @(negedge clk);
        cap_start();
        send_frame(4, 80'hF0FF0F7E);
        repeat (900) @(negedge clk);
        check_frame(4, 80'hF0FF0F7E, "slow");
        chk(quiet_viol == 0, "R11", "tx_bit change without slot", quiet_viol, 0);
        en_div = 1;
        repeat (30) @(negedge clk);

        // R10: single-octet body and unmarked octet are dropped
        cap_start();
        push(8'h00, 1'b1, 1'b1);
        push(8'h00, 1'b0, 1'b0);
        repeat (80) @(negedge clk);
        ok = (cap_n > 60);
        for (int i = 0; i < cap_n; i++) if (cap[i] !== 1'b1) ok = 1'b0;
        chk(ok, "R10", "no frame for rejected octets", cap_n, 80);
        chk(in_ready === 1'b1, "R10", "in_ready after discard", in_ready, 1);

        // R7: abort during body, delimiter fill
        idle_ones = 1'b0;
        repeat (20) @(negedge clk);
        cap_start();
        push(8'h00, 1'b1, 1'b0);
        push(8'h00, 1'b0, 1'b0);
        push(8'h00, 1'b0, 1'b0);
        abort_req = 1'b1;
        repeat (2) @(negedge clk);
        abort_req = 1'b0;
        repeat (60) @(negedge clk);
        p = 0;
        while (p < cap_n && !is_delim(p)) p++;
        while (is_delim(p)) p += 8;
        e = max_run(p, cap_n);
        chk(e >= 7, "R7", "abort run length", e, 7);
        // fill resumes: the first zero after the long run opens a delimiter
        e = p;
        while (e < cap_n && max_run(p, e) < 7) e++;
        while (e < cap_n && cap[e] === 1'b1) e++;
        chk(is_delim(e), "R7", "delimiter fill after abort", e, 0);
        chk(in_ready === 1'b1, "R7", "in_ready after abort", in_ready, 1);

        // R7: abort request during fill has no effect
        cap_start();
        abort_req = 1'b1;
        repeat (40) @(negedge clk);
        abort_req = 1'b0;
        chk(max_run(0, cap_n) <= 6, "R7", "abort ignored in fill", max_run(0, cap_n), 6);

        // R8: underrun
        cap_start();
        push(8'h00, 1'b1, 1'b0);
        push(8'h00, 1'b0, 1'b0);
        repeat (60) @(negedge clk);
        e = max_run(0, cap_n);
        chk(e >= 7, "R8", "underrun abort run", e, 7);

        // R9: stalled source loses nothing
        idle_ones = 1'b1;
        repeat (20) @(negedge clk);
        cap_start();
        push(8'hA5, 1'b1, 1'b0);
        chk(in_ready === 1'b0, "R9", "in_ready low while held", in_ready, 0);
        push(8'h3C, 1'b0, 1'b1);
        repeat (300) @(negedge clk);
        check_frame(2, 80'h3CA5, "stall");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule